// File: doc/BRIEF.md
# Self-Correcting Three-Bit SR State Machine

This block is a small clocked controller with one serial input and one output. Its state lives in three SR-type storage cells, named A, B and C from the most significant bit down. Each cell takes its own minimised set equation and clear equation. Five of the eight state codes are used. The other three are never entered in normal operation. If a fault does place the machine in one of them, the machine returns to the used set by itself within two clocks.

A synchronous, active-high master reset puts the machine in its home code. A synchronous load port writes any three-bit code into the state, including the unused ones, so the escape paths can be reached from the pins. The state bits are output directly so that a test can observe them.

Top module: `sc_fsm_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes 001 (A=0, B=0, C=1). This takes priority over `load_en` and `x_in`.
- R2: While `rst` is low and `load_en` is high at a rising edge, the state becomes `load_code` for any of the eight codes. Bit 2 is A, bit 1 is B and bit 0 is C.
- R3: Used codes step on each free edge as follows, given as next code for x=0 / x=1: 001 goes to 001/010, 010 to 011/100, 011 to 001/100, 100 to 101/100, and 101 to 001/100.
- R4: `y_out` is combinational and equals A AND `x_in`. It is therefore high only in codes 100 and 101 while `x_in` is 1.
- R5: Each cell is updated at the rising edge by its set and clear terms. Set alone stores 1, clear alone stores 0, and neither holds the value. The set terms are A: B·x, B: A'·B'·x, C: x'. The clear terms are A: C·x', B: B·x + B·C, C: x. Set and clear are never both high on the same cell.
- R6: From unused code 000, the next code is 001 for x=0 and 010 for x=1.
- R7: From unused code 110, the next code is 111 for x=0 and 100 for x=1.
- R8: From unused code 111, the next code is 001 for x=0 and 100 for x=1.
- R9: A used code never steps to an unused code. Any unused code reaches a used code within two free edges, whatever the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high master reset to code 001 |
| x_in | input | 1 | Serial data input |
| load_en | input | 1 | Synchronous state load enable for test |
| load_code | input | 3 | Code written into the state when loading ({A,B,C}) |
| y_out | output | 1 | Machine output, A AND x |
| state_q | output | 3 | Current state {A,B,C} |

## Verification
The hardest behaviour to reach is the escape from the three unused codes, because no sequence of resets and inputs ever leads there. The bench uses the synchronous load port to place the machine in 000, 110 and 111. It then releases the load and applies each input value, including two-step runs from 110, where the first step lands on another unused code. A long pseudo-random walk, with occasional loads of arbitrary codes and occasional resets, is compared every cycle against a behavioural next-code table.

// File: rtl/sc_fsm_pkg.sv
package sc_fsm_pkg;

  localparam int STATE_W = 3;
  localparam int IDX_A = 2;
  localparam int IDX_B = 1;
  localparam int IDX_C = 0;

  typedef logic [STATE_W-1:0] code_t;

  localparam code_t CODE_HOME = 3'b001;

  typedef struct packed {
    logic set;
    logic clr;
  } sr_drive_t;

  // Set and clear terms for bit A
  function automatic sr_drive_t drive_a(input code_t s, input logic x);
    sr_drive_t d;
    d.set = s[IDX_B] & x;
    d.clr = s[IDX_C] & ~x;
    return d;
  endfunction

  // Set and clear terms for bit B
  function automatic sr_drive_t drive_b(input code_t s, input logic x);
    sr_drive_t d;
    d.set = ~s[IDX_A] & ~s[IDX_B] & x;
    d.clr = (s[IDX_B] & x) | (s[IDX_B] & s[IDX_C]);
    return d;
  endfunction

  // Set and clear terms for bit C
  function automatic sr_drive_t drive_c(input code_t s, input logic x);
    sr_drive_t d;
    d.set = ~x;
    d.clr = x;
    return d;
  endfunction

  function automatic logic out_fn(input code_t s, input logic x);
    return s[IDX_A] & x;
  endfunction

  // Used codes: 001, 010, 011, 100, 101
  function automatic logic is_used(input code_t s);
    return (s != 3'b000) && (s != 3'b110) && (s != 3'b111);
  endfunction

endpackage

// File: rtl/sc_sr_cell.sv
module sc_sr_cell
  import sc_fsm_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic load_en,
  input  logic load_bit,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);

  logic q_next;

  always_comb begin
    q_next = q;
    if (set_i && !clr_i) begin
      q_next = 1'b1;
    end else if (clr_i && !set_i) begin
      q_next = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_VAL;
    end else if (load_en) begin
      q <= load_bit;
    end else begin
      q <= q_next;
    end
  end

  // R5: set and clear never arrive together
  p_sr_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    !(set_i && clr_i));

  // R5: set alone stores 1
  p_set_stores_r5: assert property (@(posedge clk) disable iff (rst)
    (!load_en && set_i && !clr_i) |=> q);

  // R5: clear alone stores 0
  p_clr_stores_r5: assert property (@(posedge clk) disable iff (rst)
    (!load_en && clr_i && !set_i) |=> !q);

  // R5: neither term holds the value
  p_idle_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !set_i && !clr_i) |=> $stable(q));

endmodule

// File: rtl/sc_sr_excite.sv
module sc_sr_excite
  import sc_fsm_pkg::*;
(
  input  code_t                    cur,
  input  logic                     x_in,
  output sr_drive_t [STATE_W-1:0]  drv,
  output logic                     y
);

  always_comb begin
    drv[IDX_A] = drive_a(cur, x_in);
    drv[IDX_B] = drive_b(cur, x_in);
    drv[IDX_C] = drive_c(cur, x_in);
    y          = out_fn(cur, x_in);
  end

endmodule

// File: rtl/sc_fsm_top.sv
module sc_fsm_top
  import sc_fsm_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         x_in,
  input  logic         load_en,
  input  logic [2:0]   load_code,
  output logic         y_out,
  output logic [2:0]   state_q
);

  code_t                    cur;
  sr_drive_t [STATE_W-1:0]  drv;
  logic                     free_step;
  logic                     cur_used;

  sc_sr_excite u_excite (
    .cur  (cur),
    .x_in (x_in),
    .drv  (drv),
    .y    (y_out)
  );

  for (genvar i = 0; i < STATE_W; i++) begin : g_cell
    sc_sr_cell #(
      .RST_VAL (CODE_HOME[i])
    ) u_cell (
      .clk      (clk),
      .rst      (rst),
      .load_en  (load_en),
      .load_bit (load_code[i]),
      .set_i    (drv[i].set),
      .clr_i    (drv[i].clr),
      .q        (cur[i])
    );
  end

  assign state_q   = cur;
  assign free_step = !rst && !load_en;
  assign cur_used  = is_used(cur);

  // R1: reset loads the home code
  p_reset_home_r1: assert property (@(posedge clk)
    rst |=> (state_q == 3'b001));

  // R2: load writes the code
  p_load_code_r2: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (state_q == $past(load_code)));

  // R4: output only in A states
  p_out_needs_a_r4: assert property (@(posedge clk) disable iff (rst)
    y_out |-> (state_q[2] && x_in));

  // R6: 000 escapes directly
  p_esc_000_r6: assert property (@(posedge clk) disable iff (rst)
    (free_step && state_q == 3'b000) |=> (state_q == 3'b001 || state_q == 3'b010));

  // R7: 110 goes to 111 or 100
  p_esc_110_r7: assert property (@(posedge clk) disable iff (rst)
    (free_step && state_q == 3'b110) |=> (state_q == 3'b111 || state_q == 3'b100));

  // R8: 111 escapes directly
  p_esc_111_r8: assert property (@(posedge clk) disable iff (rst)
    (free_step && state_q == 3'b111) |=> (state_q == 3'b001 || state_q == 3'b100));

  // R9: used codes stay used
  p_used_closed_r9: assert property (@(posedge clk) disable iff (rst)
    (free_step && cur_used) |=> is_used(state_q));

endmodule

// File: tb/sc_fsm_top_tb_top.sv
module sc_fsm_top_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       x_in = 1'b0;
  logic       load_en = 1'b0;
  logic [2:0] load_code = 3'b000;
  wire        y_out;
  wire  [2:0] state_q;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit known = 1'b0;
  logic [2:0] exp_s = 3'b000;

  always #10 clk = ~clk;

  sc_fsm_top dut_i (
    .clk       (clk),
    .rst       (rst),
    .x_in      (x_in),
    .load_en   (load_en),
    .load_code (load_code),
    .y_out     (y_out),
    .state_q   (state_q)
  );

  // Next-code table taken from the requirements
  function automatic logic [2:0] ref_next(input logic [2:0] s, input logic xi);
    int n;
    case (s)
      3'd0: n = xi ? 2 : 1;
      3'd1: n = xi ? 2 : 1;
      3'd2: n = xi ? 4 : 3;
      3'd3: n = xi ? 4 : 1;
      3'd4: n = xi ? 4 : 5;
      3'd5: n = xi ? 4 : 1;
      3'd6: n = xi ? 4 : 7;
      default: n = xi ? 4 : 1;
    endcase
    return n[2:0];
  endfunction

  function automatic bit ref_used(input logic [2:0] s);
    return !(s == 3'd0 || s == 3'd6 || s == 3'd7);
  endfunction

  function automatic string req_of(input logic [2:0] s);
    if (s == 3'd0) return "R6";
    if (s == 3'd6) return "R7";
    if (s == 3'd7) return "R8";
    return "R3";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%b exp=%b", req, what, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, check output now and state after the edge
  task automatic step(input logic r, input logic p, input logic [2:0] v,
                      input logic xi, input string req_override);
    logic [2:0] nxt;
    string req;
    rst = r; load_en = p; load_code = v; x_in = xi;
    #1;
    if (known)
      check(y_out == (exp_s[2] & xi), "R4", "y_out", {2'b00, y_out},
            {2'b00, exp_s[2] & xi});
    if (r) begin
      nxt = 3'b001; req = "R1";
    end else if (p) begin
      nxt = v; req = "R2";
    end else begin
      nxt = ref_next(exp_s, xi); req = req_of(exp_s);
      if (!ref_used(exp_s) || ref_used(nxt)) begin end
      else req = "R9";
    end
    if (req_override != "") req = req_override;
    @(posedge clk);
    @(negedge clk);
    check(state_q == nxt, req, "state", state_q, nxt);
    exp_s = nxt;
    known = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    // R1: reset state
    step(1'b1, 1'b0, 3'b000, 1'b0, "R1");
    // R1: reset beats load and input
    step(1'b0, 1'b1, 3'b110, 1'b1, "R2");
    step(1'b1, 1'b1, 3'b110, 1'b1, "R1");
    // R5: hold of C set, 001 x=0 stays 001
    step(1'b0, 1'b0, 3'b000, 1'b0, "R5");
    // R3: every used code under both inputs
    for (int c = 1; c <= 5; c++) begin
      for (int xv = 0; xv < 2; xv++) begin
        step(1'b0, 1'b1, c[2:0], 1'b0, "R2");
        step(1'b0, 1'b0, 3'b000, xv[0], "R3");
      end
    end
    // R6 R7 R8: each unused code under both inputs
    for (int u = 0; u < 3; u++) begin
      logic [2:0] uc;
      uc = (u == 0) ? 3'd0 : ((u == 1) ? 3'd6 : 3'd7);
      for (int xv = 0; xv < 2; xv++) begin
        step(1'b0, 1'b1, uc, 1'b0, "R2");
        step(1'b0, 1'b0, 3'b000, xv[0], "");
      end
    end
    // R9: recovery within two free edges for every input pair
    for (int u = 0; u < 3; u++) begin
      logic [2:0] uc;
      uc = (u == 0) ? 3'd0 : ((u == 1) ? 3'd6 : 3'd7);
      for (int pat = 0; pat < 4; pat++) begin
        step(1'b0, 1'b1, uc, 1'b0, "R2");
        step(1'b0, 1'b0, 3'b000, pat[0], "");
        step(1'b0, 1'b0, 3'b000, pat[1], "");
        check(ref_used(state_q), "R9", "recovered", state_q, exp_s);
      end
    end
    // Pseudo-random walk with occasional loads and resets
    for (int k = 0; k < 400; k++) begin
      int roll;
      logic [2:0] rc;
      roll = $urandom_range(0, 99);
      rc = 3'($urandom_range(0, 7));
      if (roll < 3)
        step(1'b1, 1'b0, rc, 1'($urandom_range(0, 1)), "");
      else if (roll < 13)
        step(1'b0, 1'b1, rc, 1'($urandom_range(0, 1)), "");
      else
        step(1'b0, 1'b0, rc, 1'($urandom_range(0, 1)), "");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule